// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a general-purpose timer. It watches an external counter value and pin, and it serves as an input-capture channel, an output-compare channel, or an edge-aligned PWM channel. A buffered variant holds a shadow compare value that takes effect only at a counter overflow. The counter, bus decoding and interrupt routing sit outside the block. Software writes a two-bit mode field and a two-bit edge/level field. Together these four bits choose the channel function. The edge/level value 00 leaves the pin to the general-purpose port and presets the idle output level.

The pin input passes through a two-flop synchronizer. Capture edges are found by comparing the newest synchronized sample with the sample before it. A capture latches the counter value and raises the channel flag. In compare modes a match between the counter and the active compare register raises the flag and applies the chosen output action on the same clock edge. The overflow pulse drives the PWM output back to its opposite level.

Top module: `cc_chan`

## Requirements
- R1: After reset the mode and edge/level fields are 00, `pin_oe_o` is 0, `pin_o` is 1, `flag_o` is 0 and `cap_o` is 0.
- R2: While the edge/level field is 00, `pin_oe_o` is 0, and one clock later `pin_o` equals the inverse of mode bit 0 (mode bit 0 = 1 presets low, 0 presets high).
- R3: A configuration write (`cfg_we_i`) always updates the edge/level field. It updates the mode field only when `tmr_stop_i` and `tmr_clr_i` are both 1; otherwise the mode field keeps its value.
- R4: With mode 00, edge/level 01 captures on rising edges only, 10 on falling edges only and 11 on both. A pin change presented before clock edge k is detected at edge k+2, and at that edge `cap_o` loads `cnt_i`. Edges of the wrong polarity, and edges in any other mode, leave `cap_o` unchanged.
- R5: A capture event sets `flag_o` at the same edge that loads `cap_o`.
- R6: With the mode field nonzero and edge/level nonzero, the channel owns the pin (`pin_oe_o` = 1). A match (`cnt_i` equal to the active compare value) applies edge/level 01 = toggle, 10 = drive 0, 11 = drive 1 to `pin_o` at that edge.
- R7: A capture or match event sets `flag_o`. `flag_clr_i` clears it, except in a cycle that also has an event, where the set wins.
- R8: In compare modes, an `ovf_i` cycle without a match drives `pin_o` to 1 for the drive-0 action and to 0 for the drive-1 action, and leaves it unchanged for toggle. When a match and an overflow fall in the same cycle, the match action wins.
- R9: With mode bit 1 clear, `cmp_we_i` writes the active compare value directly. With mode bit 1 set, it writes a shadow value, and the active value takes the shadow contents (as held before that cycle's write) only in an `ovf_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running counter value |
| ovf_i | input | 1 | Counter overflow pulse |
| pin_i | input | 1 | External pin level (asynchronous) |
| tmr_stop_i | input | 1 | Timer stopped indication |
| tmr_clr_i | input | 1 | Counter held in reset indication |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Mode field write data |
| cfg_edge_i | input | 2 | Edge/level field write data |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_data_i | input | CNT_W | Compare value write data |
| flag_clr_i | input | 1 | Channel flag clear strobe |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | 1 when the channel owns the pin, 0 for port control |
| flag_o | output | 1 | Channel event flag |
| cap_o | output | CNT_W | Captured counter value |

## Verification
Two pairs of functions can land on the same clock edge. An event setting the flag can coincide with software clearing it, and a compare match can coincide with a counter overflow, which in buffered mode is also a shadow transfer. Directed steps force each pair: a flag clear in the match cycle, and a match with an overflow under the drive-0 action. Random phases over a small counter range then make the overlaps frequent. Every cycle, each output is compared against a bench model built from the stated priorities: set over clear, match over overflow, and transfer of the pre-write shadow.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Edge/level field meaning in compare modes
  typedef enum logic [1:0] {
    ACT_PORT   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } cc_act_e;

  localparam logic [1:0] MODE_CAPTURE = 2'b00;
endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_en,
  input  logic fall_en,
  output logic hit_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0] shift_q;
  logic [SYNC_STAGES:0] shift_d;
  logic                 cur, prev;

  always_comb begin
    shift_d = {shift_q[SYNC_STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign cur   = shift_q[LAST];
  assign prev  = shift_q[SYNC_STAGES];
  assign hit_o = (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
endmodule

// File: rtl/cc_cmp_regs.sv
module cc_cmp_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_en,
  input  logic             ovf_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] act_q, act_d, shd_q, shd_d;
  logic             act_en, shd_en;

  always_comb begin
    act_d  = act_q;
    shd_d  = shd_q;
    act_en = 1'b0;
    shd_en = 1'b0;
    if (buf_en) begin
      if (we_i)  begin shd_d = data_i; shd_en = 1'b1; end
      if (ovf_i) begin act_d = shd_q;  act_en = 1'b1; end
    end else if (we_i) begin
      act_d  = data_i;
      act_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      if (act_en) act_q <= act_d;
      if (shd_en) shd_q <= shd_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/cc_out_ctl.sv
module cc_out_ctl
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic [1:0] edge_i,
  input  logic       match_i,
  input  logic       ovf_i,
  output logic       out_o
);
  logic    out_q, out_d;
  cc_act_e act;

  assign act = cc_act_e'(edge_i);

  always_comb begin
    out_d = out_q;
    if (act == ACT_PORT) begin
      out_d = ~mode_i[0];
    end else if (mode_i != MODE_CAPTURE) begin
      if (match_i) begin
        unique case (act)
          ACT_TOGGLE: out_d = ~out_q;
          ACT_LOW:    out_d = 1'b0;
          ACT_HIGH:   out_d = 1'b1;
          default:    out_d = out_q;
        endcase
      end else if (ovf_i) begin
        if (act == ACT_LOW)  out_d = 1'b1;
        if (act == ACT_HIGH) out_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else        out_q <= out_d;
  end

  assign out_o = out_q;
endmodule

// File: rtl/cc_chan.sv
module cc_chan
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic             pin_i,
  input  logic             tmr_stop_i,
  input  logic             tmr_clr_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [1:0]       cfg_edge_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             flag_clr_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cap_o
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Configuration fields
  logic [1:0] mode_q, mode_d, edge_q, edge_d;
  logic       mode_unlocked;

  assign mode_unlocked = tmr_stop_i & tmr_clr_i;

  always_comb begin
    mode_d = mode_q;
    edge_d = edge_q;
    if (cfg_we_i) begin
      edge_d = cfg_edge_i;
      if (mode_unlocked) mode_d = cfg_mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q <= 2'b00;
      edge_q <= 2'b00;
    end else begin
      mode_q <= mode_d;
      edge_q <= edge_d;
    end
  end

  logic owns_pin, cap_mode, cmp_mode;
  assign owns_pin = (edge_q != ACT_PORT);
  assign cap_mode = owns_pin & (mode_q == MODE_CAPTURE);
  assign cmp_mode = owns_pin & (mode_q != MODE_CAPTURE);

  // Capture path
  logic cap_evt;
  cc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .pin_i   (pin_i),
    .rise_en (cap_mode & edge_q[0]),
    .fall_en (cap_mode & edge_q[1]),
    .hit_o   (cap_evt)
  );

  // Compare path
  logic [CNT_W-1:0] cmp_active;
  logic             match_evt;

  cc_cmp_regs #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .buf_en   (mode_q[1]),
    .ovf_i    (ovf_i),
    .we_i     (cmp_we_i),
    .data_i   (cmp_data_i),
    .active_o (cmp_active)
  );

  assign match_evt = cmp_mode & (cnt_i == cmp_active);

  cc_out_ctl u_out (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .mode_i  (mode_q),
    .edge_i  (edge_q),
    .match_i (match_evt),
    .ovf_i   (ovf_i),
    .out_o   (pin_o)
  );

  // Capture register and flag
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (cap_evt | match_evt) flag_d = 1'b1;
    else if (flag_clr_i)     flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= cnt_i;
      flag_q <= flag_d;
    end
  end

  assign cap_o    = cap_q;
  assign flag_o   = flag_q;
  assign pin_oe_o = cmp_mode;
endmodule

// File: rtl/cc_chan_chk.sv
module cc_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ovf_i,
  input logic             tmr_stop_i,
  input logic             tmr_clr_i,
  input logic             flag_clr_i,
  input logic             pin_o,
  input logic             flag_o,
  input logic [CNT_W-1:0] cap_o,
  input logic [1:0]       mode_q,
  input logic [1:0]       edge_q,
  input logic             cap_evt,
  input logic             match_evt
);
  AST_PRESET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q == 2'b00) |=> (pin_o == !$past(mode_q[0]))); // R2

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_stop_i && tmr_clr_i) |=> $stable(mode_q)); // R3

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_o == $past(cnt_i))); // R4

  AST_EVENT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || match_evt) |=> flag_o); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !cap_evt && !match_evt) |=> !flag_o); // R7

  AST_MATCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && edge_q == 2'b11) |=> pin_o); // R6

  AST_MATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && edge_q == 2'b10) |=> !pin_o); // R6

  AST_OVF_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00 && edge_q == 2'b10 && ovf_i && !match_evt) |=> pin_o); // R8
endmodule

bind cc_chan cc_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_i      (cnt_i),
  .ovf_i      (ovf_i),
  .tmr_stop_i (tmr_stop_i),
  .tmr_clr_i  (tmr_clr_i),
  .flag_clr_i (flag_clr_i),
  .pin_o      (pin_o),
  .flag_o     (flag_o),
  .cap_o      (cap_o),
  .mode_q     (mode_q),
  .edge_q     (edge_q),
  .cap_evt    (cap_evt),
  .match_evt  (match_evt)
);

// File: tb/test_cc_chan.sv
module test_cc_chan;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt, cmp_data;
  logic         ovf, pin, stop, clr, cfg_we, cmp_we, flag_clr;
  logic [1:0]   cfg_mode, cfg_edge;
  logic         pin_o, pin_oe_o, flag_o;
  logic [W-1:0] cap_o;

  always #4 clk = ~clk;

  cc_chan #(.CNT_W(W)) i_cc_chan (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .ovf_i(ovf), .pin_i(pin),
    .tmr_stop_i(stop), .tmr_clr_i(clr), .cfg_we_i(cfg_we),
    .cfg_mode_i(cfg_mode), .cfg_edge_i(cfg_edge), .cmp_we_i(cmp_we),
    .cmp_data_i(cmp_data), .flag_clr_i(flag_clr), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .flag_o(flag_o), .cap_o(cap_o)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit model_on = 0;

  // Specification model state
  logic [1:0]   m_mode, m_edge;
  logic         m_out, m_flag;
  logic [W-1:0] m_act, m_shd, m_cap;
  logic [2:0]   m_s;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic f_match_out(logic [1:0] e, logic o);
    return (e == 2'b01) ? ~o : e[0];
  endfunction

  function automatic logic f_ovf_out(logic [1:0] e, logic o);
    return (e == 2'b10) ? 1'b1 : (e == 2'b11) ? 1'b0 : o;
  endfunction

  task automatic model_reset();
    m_mode = 0; m_edge = 0; m_out = 1; m_flag = 0;
    m_act = 0; m_shd = 0; m_cap = 0; m_s = 0;
  endtask

  task automatic model_step();
    logic cmpm, capm, match, evt, cur, prv;
    logic [W-1:0] old_shd;
    capm  = (m_mode == 0) && (m_edge != 0);
    cmpm  = (m_mode != 0) && (m_edge != 0);
    match = cmpm && (cnt == m_act);
    cur = m_s[1]; prv = m_s[2];
    evt = capm && ((m_edge[0] && cur && !prv) || (m_edge[1] && !cur && prv));
    if (evt) m_cap = cnt;
    if (m_edge == 0)  m_out = ~m_mode[0];
    else if (cmpm) m_out = match ? f_match_out(m_edge, m_out)
                                 : (ovf ? f_ovf_out(m_edge, m_out) : m_out);
    if (evt || match) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    old_shd = m_shd;
    if (m_mode[1]) begin
      if (cmp_we) m_shd = cmp_data;
      if (ovf) m_act = old_shd;
    end else if (cmp_we) m_act = cmp_data;
    m_s = {m_s[1:0], pin};
    if (cfg_we) begin
      m_edge = cfg_edge;
      if (stop && clr) m_mode = cfg_mode;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (model_on) model_step();
    @(negedge clk);
    cycles++;
    if (model_on) begin
      chk("R6 pin_oe", W'(pin_oe_o), W'((m_mode != 0) && (m_edge != 0)));
      chk("R6 pin_o",  W'(pin_o),  W'(m_out));
      chk("R7 flag",   W'(flag_o), W'(m_flag));
      chk("R4 cap",    cap_o,      m_cap);
    end
  endtask

  task automatic idle();
    ovf = 0; cfg_we = 0; cmp_we = 0; flag_clr = 0;
  endtask

  initial begin
    #1500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cnt = 0; pin = 0; stop = 0; clr = 0; cmp_data = 0;
    cfg_mode = 0; cfg_edge = 0; idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_on = 1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 pin_oe", W'(pin_oe_o), 0);
    chk("R1 pin_o",  W'(pin_o), 1);
    chk("R1 flag",   W'(flag_o), 0);
    chk("R1 cap",    cap_o, 0);

    // R3: mode write ignored while the timer is not stopped and cleared
    cfg_we = 1; cfg_mode = 2'b01; cfg_edge = 2'b00; tick(); idle();
    tick();
    chk("R3 mode locked", W'(pin_o), 1);
    // R2: preset low once the mode write is accepted
    stop = 1; clr = 1; cfg_we = 1; tick(); idle();
    tick();
    chk("R2 preset low", W'(pin_o), 0);
    chk("R2 port owns pin", W'(pin_oe_o), 0);

    // R4/R5: rising-edge capture
    cfg_we = 1; cfg_mode = 2'b00; cfg_edge = 2'b01; tick(); idle();
    cnt = 16'h1234; pin = 1;
    repeat (3) tick();
    chk("R4 capture rise", cap_o, 16'h1234);
    chk("R5 capture flag", W'(flag_o), 1);
    flag_clr = 1; tick(); idle();
    chk("R7 flag cleared", W'(flag_o), 0);
    cnt = 16'h0777; pin = 0;
    repeat (4) tick();
    chk("R4 falling ignored", cap_o, 16'h1234);
    chk("R4 no flag", W'(flag_o), 0);

    // R6/R7: set on match, in the same cycle as a flag clear
    cfg_we = 1; cfg_mode = 2'b01; cfg_edge = 2'b11; tick(); idle();
    cmp_we = 1; cmp_data = 16'd5; tick(); idle();
    chk("R6 before match", W'(pin_o), 0);
    cnt = 16'd5; flag_clr = 1; tick(); idle();
    chk("R6 set on match", W'(pin_o), 1);
    chk("R7 set wins over clear", W'(flag_o), 1);

    // R8: match versus overflow with the drive-low action
    stop = 0; clr = 0;
    cnt = 0; cfg_we = 1; cfg_edge = 2'b10; tick(); idle();
    cnt = 16'd5; ovf = 1; tick(); idle();
    chk("R8 match beats overflow", W'(pin_o), 0);
    cnt = 16'd7; ovf = 1; tick(); idle();
    chk("R8 overflow returns high", W'(pin_o), 1);

    // R9: buffered compare
    stop = 1; clr = 1; cnt = 0;
    cfg_we = 1; cfg_mode = 2'b10; cfg_edge = 2'b10; flag_clr = 1; tick(); idle();
    cmp_we = 1; cmp_data = 16'd9; tick(); idle();
    cnt = 16'd9; tick();
    chk("R9 shadow not active", W'(flag_o), 0);
    cnt = 0; ovf = 1; tick(); idle();
    cnt = 16'd9; tick();
    chk("R9 active after overflow", W'(pin_o), 0);
    chk("R9 match flag", W'(flag_o), 1);

    // Random phases checked against the model every cycle
    for (int ph = 0; ph < 24; ph++) begin
      stop = 1; clr = 1; cfg_we = 1;
      cfg_mode = 2'($urandom); cfg_edge = 2'($urandom);
      tick(); idle(); stop = 0; clr = 0;
      for (int i = 0; i < 150; i++) begin
        cnt      = W'($urandom % 8);
        ovf      = ($urandom % 6) == 0;
        if (($urandom % 4) == 0) pin = ~pin;
        flag_clr = ($urandom % 5) == 0;
        cmp_we   = ($urandom % 7) == 0;
        cmp_data = W'($urandom % 8);
        cfg_we   = ($urandom % 40) == 0;
        cfg_mode = 2'($urandom); cfg_edge = 2'($urandom);
        stop     = ($urandom % 2) == 0;
        clr      = ($urandom % 2) == 0;
        tick();
      end
      idle();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule